// File: doc/BRIEF.md
# Scrolling Pixel Store with Mirrored Refresh Scan

This block keeps a bitmap of 104 columns by 65 rows, two bits for each pixel, for a small matrix panel. The host side writes single pixels by row and column, and it can read any pixel back. A refresh scanner sweeps every common, and every segment within a common, at one pixel per clock. It delivers each pixel value with the scan position it belongs to.

Three controls act only on the refresh path and leave host addressing untouched. A loadable first-row register rotates the bitmap vertically to give scrolling. A segment mirror reverses the column order, and a common mirror reverses the row order, so the panel can be mounted either way round.

Top module: `scroll_pixel_ram`

## Requirements
- R1: While `rst_n` is low, `pix_valid`, `pix_seg`, `pix_com`, `pix_data` and `hrd_data` are all zero, and the start-line register is 0.
- R2: After reset the scan moves one segment per clock from 0 to 103. After segment 103 it returns to 0 and the common advances, wrapping from 64 to 0. `pix_seg`, `pix_com` and `pix_data` are registered together, one clock after the scan position, and `pix_valid` is 1 from the first clock after reset.
- R3: A host write with `wr_en`=1 stores `wr_data` at (`wr_row`,`wr_col`). `hrd_data` returns the pixel at (`hrd_row`,`hrd_col`) one clock after the address is presented. This holds for every row 0..64, including rows off the visible window.
- R4: With start line SL and no mirroring, common k shows RAM row (SL + k) mod 65. For example, SL=48 puts row 48 on common 0 and row 0 on common 17.
- R5: Loading `sl_value` with `sl_load`=1 sets SL on the next clock. Any value of 65 or more is stored as 64.
- R6: With `seg_flip`=1, segment s shows RAM column 103 - s.
- R7: With `com_flip`=1, common k shows RAM row (64 - k + SL) mod 65. The mirror is applied before the offset is added.
- R8: A host write and a read of the same pixel on the same clock return the old value, both on `pix_data` and on `hrd_data`.
- R9: A write with `wr_row` ≥ 65 or `wr_col` ≥ 104 changes no stored pixel. A host read of such an address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host pixel write strobe |
| wr_row | input | 7 | Host write row |
| wr_col | input | 7 | Host write column |
| wr_data | input | 2 | Host write pixel value |
| sl_load | input | 1 | Load start line from `sl_value` |
| sl_value | input | 7 | New start line (clamped to 64) |
| seg_flip | input | 1 | Reverse segment order on refresh |
| com_flip | input | 1 | Reverse common order on refresh |
| hrd_row | input | 7 | Host read row |
| hrd_col | input | 7 | Host read column |
| hrd_data | output | 2 | Host read pixel, one clock latency |
| pix_valid | output | 1 | Refresh output valid |
| pix_seg | output | 7 | Segment index of `pix_data` |
| pix_com | output | 7 | Common index of `pix_data` |
| pix_data | output | 2 | Refresh pixel value |

## Verification
The bitmap is first filled with a pattern that varies with both row and column, so a wrong row or a wrong column shows up as a wrong pixel value. Whole frames are then scanned with no offset, with start line 48, and with a load of 100 that must clamp to 64. Further frames run with segment mirroring alone and with common mirroring on a nonzero offset, which separates "mirror then offset" from "offset then mirror". A phase that writes exactly the pixel being refreshed and host-read on each clock exposes read-during-write ordering. A final phase writes out-of-range addresses, and the frame after it shows that no aliased pixel was changed.

// File: rtl/spr_pkg.sv
package spr_pkg;

  // Refresh row for a given common: mirror first, then rotate by start line.
  function automatic int unsigned fold_row(int unsigned com, int unsigned sl,
                                           bit flip, int unsigned rows);
    int unsigned c;
    int unsigned s;
    c = flip ? (rows - 1 - com) : com;
    s = c + sl;
    return (s >= rows) ? (s - rows) : s;
  endfunction

  function automatic int unsigned mirror_col(int unsigned seg, bit flip,
                                             int unsigned cols);
    return flip ? (cols - 1 - seg) : seg;
  endfunction

  function automatic int unsigned clamp_line(int unsigned v, int unsigned rows);
    return (v >= rows) ? (rows - 1) : v;
  endfunction

  function automatic bit in_grid(int unsigned r, int unsigned c,
                                 int unsigned rows, int unsigned cols);
    return (r < rows) && (c < cols);
  endfunction

endpackage

// File: rtl/spr_scan_ctr.sv
module spr_scan_ctr #(
  parameter int COLS = 104,
  parameter int ROWS = 65,
  localparam int CW = $clog2(COLS),
  localparam int RW = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [CW-1:0] seg_o,
  output logic [RW-1:0] com_o,
  output logic          line_end_o
);
  localparam logic [CW-1:0] SEG_LAST = CW'(COLS - 1);
  localparam logic [RW-1:0] COM_LAST = RW'(ROWS - 1);

  assign line_end_o = (seg_o == SEG_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seg_o <= '0;
      com_o <= '0;
    end else if (line_end_o) begin
      seg_o <= '0;
      com_o <= (com_o == COM_LAST) ? '0 : com_o + 1'b1;
    end else begin
      seg_o <= seg_o + 1'b1;
    end
  end
endmodule

// File: rtl/spr_addr_map.sv
module spr_addr_map #(
  parameter int COLS = 104,
  parameter int ROWS = 65,
  localparam int CW = $clog2(COLS),
  localparam int RW = $clog2(ROWS)
) (
  input  logic [CW-1:0] seg_i,
  input  logic [RW-1:0] com_i,
  input  logic [RW-1:0] sl_i,
  input  logic          seg_flip_i,
  input  logic          com_flip_i,
  output logic [RW-1:0] row_o,
  output logic [CW-1:0] col_o
);
  import spr_pkg::*;

  always_comb begin
    row_o = RW'(fold_row(int'(com_i), int'(sl_i), com_flip_i, ROWS));
    col_o = CW'(mirror_col(int'(seg_i), seg_flip_i, COLS));
  end
endmodule

// File: rtl/spr_store.sv
module spr_store #(
  parameter int COLS = 104,
  parameter int ROWS = 65,
  parameter int BPP  = 2,
  localparam int CW = $clog2(COLS),
  localparam int RW = $clog2(ROWS),
  localparam int LW = COLS * BPP
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [RW-1:0]  wr_row,
  input  logic [CW-1:0]  wr_col,
  input  logic [BPP-1:0] wr_data,
  input  logic [RW-1:0]  rf_row,
  input  logic [CW-1:0]  rf_col,
  output logic [BPP-1:0] rf_data,
  input  logic [RW-1:0]  hr_row,
  input  logic [CW-1:0]  hr_col,
  output logic [BPP-1:0] hr_data,
  output logic           wr_hit_o
);
  import spr_pkg::*;

  // One packed word per row keeps the array at ROWS entries.
  logic [LW-1:0] line_q [ROWS];
  logic          hr_ok;

  assign wr_hit_o = wr_en && in_grid(int'(wr_row), int'(wr_col), ROWS, COLS);
  assign hr_ok    = in_grid(int'(hr_row), int'(hr_col), ROWS, COLS);

  always_ff @(posedge clk) begin
    if (wr_hit_o) line_q[wr_row][int'(wr_col)*BPP +: BPP] <= wr_data;
  end

  // Both read ports are registered; a same-edge write is seen next cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rf_data <= '0;
      hr_data <= '0;
    end else begin
      rf_data <= line_q[rf_row][int'(rf_col)*BPP +: BPP];
      hr_data <= hr_ok ? line_q[hr_row][int'(hr_col)*BPP +: BPP] : '0;
    end
  end
endmodule

// File: rtl/scroll_pixel_ram.sv
module scroll_pixel_ram #(
  parameter int COLS = 104,
  parameter int ROWS = 65,
  parameter int BPP  = 2,
  localparam int CW = $clog2(COLS),
  localparam int RW = $clog2(ROWS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [RW-1:0]  wr_row,
  input  logic [CW-1:0]  wr_col,
  input  logic [BPP-1:0] wr_data,
  input  logic           sl_load,
  input  logic [RW-1:0]  sl_value,
  input  logic           seg_flip,
  input  logic           com_flip,
  input  logic [RW-1:0]  hrd_row,
  input  logic [CW-1:0]  hrd_col,
  output logic [BPP-1:0] hrd_data,
  output logic           pix_valid,
  output logic [CW-1:0]  pix_seg,
  output logic [RW-1:0]  pix_com,
  output logic [BPP-1:0] pix_data
);
  import spr_pkg::*;

  // Named internal events, brought out for the checker.
  logic [CW-1:0] scan_seg;
  logic [RW-1:0] scan_com;
  logic          scan_line_end;
  logic [RW-1:0] sl_q;
  logic [RW-1:0] map_row;
  logic [CW-1:0] map_col;
  logic          wr_hit;

  spr_scan_ctr #(.COLS(COLS), .ROWS(ROWS)) u_scan (
    .clk       (clk),
    .rst_n     (rst_n),
    .seg_o     (scan_seg),
    .com_o     (scan_com),
    .line_end_o(scan_line_end)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       sl_q <= '0;
    else if (sl_load) sl_q <= RW'(clamp_line(int'(sl_value), ROWS));
  end

  spr_addr_map #(.COLS(COLS), .ROWS(ROWS)) u_map (
    .seg_i     (scan_seg),
    .com_i     (scan_com),
    .sl_i      (sl_q),
    .seg_flip_i(seg_flip),
    .com_flip_i(com_flip),
    .row_o     (map_row),
    .col_o     (map_col)
  );

  spr_store #(.COLS(COLS), .ROWS(ROWS), .BPP(BPP)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_row  (wr_row),
    .wr_col  (wr_col),
    .wr_data (wr_data),
    .rf_row  (map_row),
    .rf_col  (map_col),
    .rf_data (pix_data),
    .hr_row  (hrd_row),
    .hr_col  (hrd_col),
    .hr_data (hrd_data),
    .wr_hit_o(wr_hit)
  );

  // Position tags travel with the registered pixel.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_valid <= 1'b0;
      pix_seg   <= '0;
      pix_com   <= '0;
    end else begin
      pix_valid <= 1'b1;
      pix_seg   <= scan_seg;
      pix_com   <= scan_com;
    end
  end
endmodule

// File: rtl/spr_checker.sv
module spr_checker #(
  parameter int COLS = 104,
  parameter int ROWS = 65,
  localparam int CW = $clog2(COLS),
  localparam int RW = $clog2(ROWS)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] scan_seg,
  input logic [RW-1:0] scan_com,
  input logic [RW-1:0] sl_q,
  input logic          sl_load,
  input logic [RW-1:0] sl_value,
  input logic [RW-1:0] map_row,
  input logic [CW-1:0] map_col,
  input logic          pix_valid,
  input logic [CW-1:0] pix_seg,
  input logic [RW-1:0] pix_com
);
  localparam logic [CW-1:0] SEG_LAST = CW'(COLS - 1);
  localparam logic [RW-1:0] COM_LAST = RW'(ROWS - 1);

  a_r2_seg_step: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_seg != SEG_LAST) |=> (scan_seg == $past(scan_seg) + 1'b1) && (scan_com == $past(scan_com)));

  a_r2_line_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_seg == SEG_LAST) |=> (scan_seg == '0) &&
      (scan_com == (($past(scan_com) == COM_LAST) ? '0 : $past(scan_com) + 1'b1)));

  a_r2_tag_follow: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> (pix_seg == $past(scan_seg)) && (pix_com == $past(scan_com)));

  a_r2_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> pix_valid);

  a_r5_clamp_load: assert property (@(posedge clk) disable iff (!rst_n)
    sl_load |=> sl_q == (($past(sl_value) > COM_LAST) ? COM_LAST : $past(sl_value)));

  a_r5_line_range: assert property (@(posedge clk) disable iff (!rst_n)
    sl_q <= COM_LAST);

  a_r4_map_range: assert property (@(posedge clk) disable iff (!rst_n)
    (map_row <= COM_LAST) && (map_col <= SEG_LAST));
endmodule

bind scroll_pixel_ram spr_checker #(.COLS(COLS), .ROWS(ROWS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scan_seg (scan_seg),
  .scan_com (scan_com),
  .sl_q     (sl_q),
  .sl_load  (sl_load),
  .sl_value (sl_value),
  .map_row  (map_row),
  .map_col  (map_col),
  .pix_valid(pix_valid),
  .pix_seg  (pix_seg),
  .pix_com  (pix_com)
);

// File: tb/sim_scroll_pixel_ram.sv
module sim_scroll_pixel_ram;
  localparam int NC = 104;
  localparam int NR = 65;
  localparam int FRAME = NC * NR;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [6:0] wr_row = '0;
  logic [6:0] wr_col = '0;
  logic [1:0] wr_data = '0;
  logic       sl_load = 1'b0;
  logic [6:0] sl_value = '0;
  logic       seg_flip = 1'b0;
  logic       com_flip = 1'b0;
  logic [6:0] hrd_row = '0;
  logic [6:0] hrd_col = '0;
  logic [1:0] hrd_data;
  logic       pix_valid;
  logic [6:0] pix_seg;
  logic [6:0] pix_com;
  logic [1:0] pix_data;

  always #4 clk = ~clk;

  scroll_pixel_ram u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_row(wr_row), .wr_col(wr_col),
    .wr_data(wr_data), .sl_load(sl_load), .sl_value(sl_value),
    .seg_flip(seg_flip), .com_flip(com_flip), .hrd_row(hrd_row),
    .hrd_col(hrd_col), .hrd_data(hrd_data), .pix_valid(pix_valid),
    .pix_seg(pix_seg), .pix_com(pix_com), .pix_data(pix_data)
  );

  int errors = 0;
  int checks = 0;
  int ram [NR][NC];
  bit known [NR][NC];
  int m_seg = 0, m_com = 0, m_sl = 0;
  string ptag = "R2";
  string htag = "R3";

  task automatic check(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int ref_row(int k, int sl, bit fl);
    int base;
    base = fl ? (NR - 1) - k : k;
    return (base + sl) % NR;
  endfunction

  function automatic int ref_col(int s, bit fl);
    return fl ? (NC - 1) - s : s;
  endfunction

  // One clock of the reference model, then compare at the falling edge.
  task automatic tick();
    int er, ec, ep, es, eco, eh;
    bit ek, ehk;
    er = ref_row(m_com, m_sl, com_flip);
    ec = ref_col(m_seg, seg_flip);
    ek = known[er][ec];
    ep = ram[er][ec];
    es = m_seg;
    eco = m_com;
    if (hrd_row < NR && hrd_col < NC) begin
      ehk = known[hrd_row][hrd_col];
      eh = ram[hrd_row][hrd_col];
    end else begin
      ehk = 1'b1;
      eh = 0;
    end
    @(posedge clk);
    if (wr_en && wr_row < NR && wr_col < NC) begin
      ram[wr_row][wr_col] = int'(wr_data);
      known[wr_row][wr_col] = 1'b1;
    end
    if (sl_load) m_sl = (sl_value > 64) ? 64 : int'(sl_value);
    m_seg++;
    if (m_seg == NC) begin
      m_seg = 0;
      m_com = (m_com + 1) % NR;
    end
    @(negedge clk);
    check("R2", int'(pix_seg), es, "pix_seg");
    check("R2", int'(pix_com), eco, "pix_com");
    check("R2", int'(pix_valid), 1, "pix_valid");
    if (ek) check(ptag, int'(pix_data), ep, "pix_data");
    if (ehk) check(htag, int'(hrd_data), eh, "hrd_data");
  endtask

  task automatic idle_frame();
    wr_en = 1'b0;
    sl_load = 1'b0;
    for (int i = 0; i < FRAME; i++) tick();
  endtask

  task automatic load_line(int v);
    sl_value = 7'(v);
    sl_load = 1'b1;
    tick();
    sl_load = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", int'(pix_valid), 0, "pix_valid");
    check("R1", int'(pix_seg), 0, "pix_seg");
    check("R1", int'(pix_com), 0, "pix_com");
    check("R1", int'(pix_data), 0, "pix_data");
    check("R1", int'(hrd_data), 0, "hrd_data");
    rst_n = 1'b1;

    // R3: fill with a row- and column-dependent pattern, read back one behind
    ptag = "R3";
    htag = "R3";
    for (int r = 0; r < NR; r++) begin
      for (int c = 0; c < NC; c++) begin
        wr_en = 1'b1;
        wr_row = 7'(r);
        wr_col = 7'(c);
        wr_data = 2'((r + 3 * c + r / 4) % 4);
        tick();
        hrd_row = 7'(r);
        hrd_col = 7'(c);
      end
    end
    wr_en = 1'b0;

    // R2 / R4: no offset, then start line 48 (R4), refresh checked on pix_data
    ptag = "R2";
    idle_frame();
    ptag = "R4";
    load_line(48);
    idle_frame();

    // R5: 100 is clamped to 64
    ptag = "R5";
    load_line(100);
    idle_frame();

    // R6: segment mirror
    ptag = "R6";
    load_line(0);
    seg_flip = 1'b1;
    idle_frame();

    // R7: common mirror applied before the offset
    ptag = "R7";
    seg_flip = 1'b0;
    com_flip = 1'b1;
    load_line(10);
    idle_frame();

    // R8: write exactly the pixel being refreshed and host-read each clock
    ptag = "R8";
    htag = "R8";
    for (int i = 0; i < 3000; i++) begin
      wr_en = 1'b1;
      wr_row = 7'(ref_row(m_com, m_sl, com_flip));
      wr_col = 7'(ref_col(m_seg, seg_flip));
      wr_data = 2'(~ram[wr_row][wr_col]);
      hrd_row = wr_row;
      hrd_col = wr_col;
      tick();
    end

    // R9: out-of-range writes leave storage unchanged, reads give 0
    ptag = "R9";
    htag = "R9";
    for (int i = 0; i < 600; i++) begin
      wr_en = 1'b1;
      wr_data = 2'(i);
      if (i % 2 == 0) begin
        wr_row = 7'(65 + (i % 63));
        wr_col = 7'(i % NC);
      end else begin
        wr_row = 7'(i % NR);
        wr_col = 7'(104 + (i % 24));
      end
      hrd_row = wr_row;
      hrd_col = wr_col;
      tick();
    end
    hrd_row = 7'd5;
    hrd_col = 7'd3;
    com_flip = 1'b0;
    idle_frame();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule